// File: doc/BRIEF.md
# Coprocessor I/O Port Decoder

This block sits on a legacy I/O bus and claims a 16-port window that belongs to a math coprocessor. It keeps two sticky bits: the coprocessor-error interrupt request (IRQ13) and a busy latch. When the modelled coprocessor reports an error, both bits are set.

Software acknowledges the error with byte writes into the window. Any byte write drops IRQ13. A byte write to the window's first port also clears the busy latch. A byte write to the second port produces a one-cycle coprocessor reset pulse. All other accesses in the window are trapped and reported as a one-cycle unsupported-access pulse. This covers the opcode-transfer ports, the remaining byte ports, every access wider than one byte and every read. A read in the window returns all-ones, the value of an unused port.

An access is byte-wide when exactly one bit of `io_be` is set; which lane it is does not matter. Write data carries no meaning here, so the bus has no write-data path. All outputs except `io_rdata` are registered and change on the clock edge that samples the access.

Top module: `fpu_port_decoder`

## Requirements
- R1: An access whose address lies outside 0x00F0..0x00FF leaves `irq13_o` and `busy_o` unchanged, raises neither pulse, and reads 0 on `io_rdata`.
- R2: A byte write (exactly one `io_be` bit set) to any port 0x00F0..0x00FF clears `irq13_o` on the next cycle.
- R3: A byte write to port 0x00F0 clears `busy_o` on the next cycle.
- R4: A byte write to port 0x00F1 raises `cop_reset_o` for exactly one cycle, on the cycle after the write, and leaves `busy_o` unchanged.
- R5: A byte write to any window port other than 0x00F0 and 0x00F1 (including the opcode ports 0x00F8, 0x00FA, 0x00FC) raises `bad_access_o` for exactly one cycle after the write, and does not clear `busy_o`.
- R6: A write in the window with zero or more than one `io_be` bit set raises `bad_access_o` for one cycle and changes neither `irq13_o` nor `busy_o`.
- R7: A read in the window of any width drives `io_rdata` to all-ones in the same cycle and raises `bad_access_o` for one cycle after it, without changing `irq13_o` or `busy_o`.
- R8: `cop_err_in` high sets both `irq13_o` and `busy_o` on the next cycle. They hold until cleared as in R2/R3, and a set in the same cycle as a clearing write wins.
- R9: With `rst_n` low at a clock edge, all registered outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W (16) | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_be | input | DATA_W/8 (4) | Byte enables, one bit set means byte access |
| io_rdata | output | DATA_W (32) | Read data, all-ones for a read in the window |
| cop_err_in | input | 1 | Error report from the coprocessor model |
| irq13_o | output | 1 | Coprocessor error interrupt level |
| busy_o | output | 1 | Busy latch state |
| cop_reset_o | output | 1 | One-cycle coprocessor reset pulse |
| bad_access_o | output | 1 | One-cycle unsupported-access pulse |

## Verification
The hardest case to reach is a clearing write that arrives in the very cycle the coprocessor raises a new error. That case decides whether an error is lost. The bench drives `cop_err_in` together with a byte write to 0x00F0 and checks that both bits stay set. A second hard case is a trap that must leave the latches untouched. To show this at the ports, the bench first sets both bits through `cop_err_in`, then issues wide writes, zero-enable writes, reads and out-of-window traffic, and checks every cycle that nothing has been cleared. It also sweeps all sixteen offsets, re-arming the error before each write.

// File: rtl/cpio_pkg.sv
package cpio_pkg;

   // Decoded intent of one bus cycle
   typedef struct packed {
      logic drop_irq;   // byte write anywhere in the window
      logic clr_busy;   // byte write to the clear-busy port
      logic cop_rst;    // byte write to the reset port
      logic trap;       // anything the window does not serve
   } acc_cmd_t;

   localparam int unsigned CLR_BUSY_OFS = 0;
   localparam int unsigned COP_RST_OFS  = 1;

endpackage

// File: rtl/cpio_decode.sv
module cpio_decode
   import cpio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BE_W      = 4,
   parameter int unsigned BASE      = 'hF0,
   parameter int unsigned SPAN_LOG2 = 4
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [BE_W-1:0]   io_be,
   output acc_cmd_t          cmd,
   output logic              rd_hit
);

   localparam int unsigned TAG_W = ADDR_W - SPAN_LOG2;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
   localparam logic [TAG_W-1:0]  BASE_TAG = BASE_V[ADDR_W-1:SPAN_LOG2];
   localparam logic [SPAN_LOG2-1:0] CLR_O = SPAN_LOG2'(CLR_BUSY_OFS);
   localparam logic [SPAN_LOG2-1:0] RST_O = SPAN_LOG2'(COP_RST_OFS);

   logic                 hit;
   logic                 is_byte;
   logic [SPAN_LOG2-1:0] ofs;
   logic                 byte_wr;

   assign hit = (io_addr[ADDR_W-1:SPAN_LOG2] == BASE_TAG);
   assign ofs = io_addr[SPAN_LOG2-1:0];

   generate
      if (BE_W == 1) begin : g_single_lane
         assign is_byte = io_be[0];
      end else begin : g_multi_lane
         assign is_byte = $onehot(io_be);
      end
   endgenerate

   assign byte_wr = hit & io_wr & is_byte;

   always_comb begin
      cmd          = '0;
      cmd.drop_irq = byte_wr;
      cmd.clr_busy = byte_wr & (ofs == CLR_O);
      cmd.cop_rst  = byte_wr & (ofs == RST_O);
      cmd.trap     = hit & (io_rd
                            | (io_wr & ~is_byte)
                            | (byte_wr & (ofs != CLR_O) & (ofs != RST_O)));
   end

   assign rd_hit = hit & io_rd;

endmodule

// File: rtl/cpio_sticky.sv
module cpio_sticky #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               q_o[i] <= 1'b0;
            else if (set_i[i])
               q_o[i] <= 1'b1;     // a fresh error outranks a clear
            else if (clr_i[i])
               q_o[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/cpio_pulse.sv
module cpio_pulse #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else
         q_o <= d_i;
   end

endmodule

// File: rtl/fpu_port_decoder.sv
module fpu_port_decoder
   import cpio_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE      = 'hF0,
   parameter int unsigned SPAN_LOG2 = 4,
   parameter int unsigned BE_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [BE_W-1:0]   io_be,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              cop_err_in,
   output logic              irq13_o,
   output logic              busy_o,
   output logic              cop_reset_o,
   output logic              bad_access_o
);

   localparam int unsigned SPAN = 1 << SPAN_LOG2;

   generate
      if (SPAN_LOG2 < 1 || SPAN_LOG2 >= ADDR_W) begin : g_bad_span
         $error("SPAN_LOG2 out of range");
      end
      if (DATA_W % 8 != 0 || BE_W != DATA_W / 8) begin : g_bad_width
         $error("DATA_W must be whole bytes matching BE_W");
      end
      if (BASE % SPAN != 0) begin : g_bad_base
         $error("BASE must be aligned to the window size");
      end
   endgenerate

   acc_cmd_t   cmd;
   logic       rd_hit;
   logic [1:0] sticky_q;
   logic [1:0] pulse_q;

   cpio_decode #(
      .ADDR_W   (ADDR_W),
      .BE_W     (BE_W),
      .BASE     (BASE),
      .SPAN_LOG2(SPAN_LOG2)
   ) u_dec (
      .io_addr(io_addr),
      .io_wr  (io_wr),
      .io_rd  (io_rd),
      .io_be  (io_be),
      .cmd    (cmd),
      .rd_hit (rd_hit)
   );

   // bit 1: IRQ13, bit 0: busy latch
   cpio_sticky #(.W(2)) u_sticky (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i({cop_err_in, cop_err_in}),
      .clr_i({cmd.drop_irq, cmd.clr_busy}),
      .q_o  (sticky_q)
   );

   // bit 1: coprocessor reset, bit 0: unsupported access
   cpio_pulse #(.W(2)) u_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({cmd.cop_rst, cmd.trap}),
      .q_o  (pulse_q)
   );

   assign irq13_o      = sticky_q[1];
   assign busy_o       = sticky_q[0];
   assign cop_reset_o  = pulse_q[1];
   assign bad_access_o = pulse_q[0];
   assign io_rdata     = rd_hit ? '1 : '0;

endmodule

// File: rtl/cpio_chk.sv
module cpio_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE      = 'hF0,
   parameter int unsigned SPAN_LOG2 = 4,
   parameter int unsigned BE_W      = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [BE_W-1:0]   io_be,
   input logic [DATA_W-1:0] io_rdata,
   input logic              cop_err_in,
   input logic              irq13_o,
   input logic              busy_o,
   input logic              cop_reset_o,
   input logic              bad_access_o
);

   localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + (1 << SPAN_LOG2) - 1);

   logic in_win, one_be;
   assign in_win = (io_addr >= LO) && (io_addr <= HI);
   assign one_be = ($countones(io_be) == 1);

   // R1
   outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_win && !cop_err_in) |=> ($stable(irq13_o) && $stable(busy_o)
                                    && !cop_reset_o && !bad_access_o));

   // R2
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && io_wr && one_be && !cop_err_in) |=> !irq13_o);

   // R3
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == LO && io_wr && one_be && !cop_err_in) |=> !busy_o);

   // R4
   reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == LO + 1 && io_wr && one_be) |=> cop_reset_o);

   // R4
   reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_reset_o && !(io_addr == LO + 1 && io_wr && one_be)) |=> !cop_reset_o);

   // R7
   read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && io_rd) |-> (io_rdata == '1));

   // R7
   read_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && io_rd) |=> bad_access_o);

   // R8
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_err_in |=> (irq13_o && busy_o));

endmodule

bind fpu_port_decoder cpio_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .BASE     (BASE),
   .SPAN_LOG2(SPAN_LOG2),
   .BE_W     (BE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_addr     (io_addr),
   .io_wr       (io_wr),
   .io_rd       (io_rd),
   .io_be       (io_be),
   .io_rdata    (io_rdata),
   .cop_err_in  (cop_err_in),
   .irq13_o     (irq13_o),
   .busy_o      (busy_o),
   .cop_reset_o (cop_reset_o),
   .bad_access_o(bad_access_o)
);

// File: tb/sim_fpu_port_decoder.sv
`timescale 1ns/1ps
module sim_fpu_port_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [3:0]  io_be = '0;
   logic [31:0] io_rdata;
   logic        cop_err_in = 1'b0;
   logic        irq13_o, busy_o, cop_reset_o, bad_access_o;

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit m_irq = 0, m_busy = 0, m_rst = 0, m_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   fpu_port_decoder u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_be(io_be), .io_rdata(io_rdata),
      .cop_err_in(cop_err_in), .irq13_o(irq13_o), .busy_o(busy_o),
      .cop_reset_o(cop_reset_o), .bad_access_o(bad_access_o)
   );

   task automatic expect_bit(input string req, input string name,
                             input logic act, input bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      expect_bit(req, "irq13_o", irq13_o, m_irq);
      expect_bit(req, "busy_o", busy_o, m_busy);
      expect_bit(req, "cop_reset_o", cop_reset_o, m_rst);
      expect_bit(req, "bad_access_o", bad_access_o, m_bad);
   endtask

   // One bus cycle: drive at negedge, check read data, advance model, compare
   task automatic step(input logic [15:0] a, input bit w, input bit r,
                       input logic [3:0] be, input bit e, input string req);
      bit hit, isb, clr;
      logic [31:0] exp_rd;
      int ofs;
      io_addr = a; io_wr = w; io_rd = r; io_be = be; cop_err_in = e;
      hit = (a >= 16'h00F0) && (a <= 16'h00FF);
      isb = ($countones(be) == 1);
      ofs = int'(a) - 'hF0;
      #1;
      exp_rd = (hit && r) ? 32'hFFFF_FFFF : 32'h0;
      checks++;
      if (io_rdata !== exp_rd) begin
         fails++;
         $display("FAIL %s io_rdata actual=%h expected=%h at %0t", req, io_rdata, exp_rd, $time);
      end
      clr = hit && w && isb;
      if (!rst_n) begin
         m_irq = 0; m_busy = 0; m_rst = 0; m_bad = 0;
      end else begin
         m_irq  = e ? 1'b1 : (clr ? 1'b0 : m_irq);
         m_busy = e ? 1'b1 : ((clr && ofs == 0) ? 1'b0 : m_busy);
         m_rst  = clr && ofs == 1;
         m_bad  = hit && (r || (w && (!isb || ofs > 1)));
      end
      @(posedge clk);
      @(negedge clk);
      compare_all(req);
   endtask

   task automatic idle(input string req);
      step(16'h0000, 0, 0, 4'h0, 0, req);
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R9: outputs cleared under reset
      step(16'h00F1, 1, 0, 4'h1, 1, "R9");
      idle("R9");
      rst_n = 1'b1;
      idle("R9");

      // R8: error sets both bits, which then hold
      step(16'h0000, 0, 0, 4'h0, 1, "R8");
      idle("R8");
      idle("R8");

      // R1: traffic around the window leaves state alone
      step(16'h00EF, 1, 0, 4'h1, 0, "R1");
      step(16'h0100, 1, 0, 4'h2, 0, "R1");
      step(16'h01F0, 1, 0, 4'h1, 0, "R1");
      step(16'h10F1, 1, 0, 4'h8, 0, "R1");
      step(16'h00E0, 0, 1, 4'hF, 0, "R1");

      // R6: wide and zero-enable writes trap without clearing
      step(16'h00F0, 1, 0, 4'h3, 0, "R6");
      step(16'h00F1, 1, 0, 4'hF, 0, "R6");
      step(16'h00F0, 1, 0, 4'h0, 0, "R6");
      idle("R6");

      // R7: reads return all-ones and trap, narrow and wide
      step(16'h00F0, 0, 1, 4'h1, 0, "R7");
      step(16'h00FC, 0, 1, 4'hF, 0, "R7");
      idle("R7");

      // R4 and R2: reset port pulses once, drops IRQ, keeps busy
      step(16'h00F1, 1, 0, 4'h4, 0, "R4");
      idle("R4");
      idle("R4");

      // R3: clear-busy port
      step(16'h00F0, 1, 0, 4'h8, 0, "R3");
      idle("R3");

      // R5: opcode ports and other offsets trap and drop IRQ only
      foreach (m_opc[k]) begin
         step(16'h0000, 0, 0, 4'h0, 1, "R8");
         step(m_opc[k], 1, 0, 4'h1, 0, "R5");
         idle("R5");
      end

      // R8: set wins over a simultaneous clear
      step(16'h00F0, 1, 0, 4'h1, 1, "R8");
      idle("R8");

      // R2: sweep of every offset, re-arming the error first
      for (int i = 0; i < 16; i++) begin
         step(16'h0000, 0, 0, 4'h0, 1, "R2");
         step(16'h00F0 + 16'(i), 1, 0, 4'h1 << (i % 4), 0, "R2");
         idle("R2");
      end

      // R9: reset mid-state
      step(16'h0000, 0, 0, 4'h0, 1, "R9");
      rst_n = 1'b0;
      idle("R9");
      rst_n = 1'b1;
      idle("R9");

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   logic [15:0] m_opc [5] = '{16'h00F8, 16'h00FA, 16'h00FC, 16'h00F2, 16'h00FF};

endmodule